// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Lookup with Requester-Chosen Fill Way

The block holds a small set-associative cache for a 12-bit byte address: four ways, four sets per way and eight bytes per line. On every access the set index opens one line in each of the four ways. Each way compares its stored tag with the tag field of the address. The way whose tag is equal and whose valid bit is set is the only line allowed onto the data path. The requester gets a single active-low hit flag and the addressed byte at once. On a hit it can also overwrite that one byte at the next rising clock edge.

When the requester loads a line after a miss, or changes a valid bit, it names the target way on a 2-bit way-pick input. While either of those two strobes is low, the way enables collapse from "all four ways" to the one named way. The load or valid update then lands only in the indexed line of that way. Choosing which way to evict belongs to the requester. Once the line and its tag are written and the valid bit is set, the interrupted access, repeated with the same address, hits.

Top module: `setassoc_cache`

## Requirements
- R1: The address splits into a byte offset in bits 2:0, a set index in bits 4:3 and a tag in bits 11:5. Only lines of the indexed set take part in a lookup.
- R2: hit_n is low exactly when sel_n is low and an enabled way at the indexed set holds an equal tag with its valid bit at 1. Otherwise hit_n is high, and it is always high while sel_n is high.
- R3: rdata equals byte `offset` of the hitting way's line when sel_n, rd_n and hit_n are all low. In every other case rdata is 8'h00.
- R4: At a rising edge with sel_n and wr_n low, fill_n and setv_n high, and a hit, wdata replaces only the byte at the offset in the hitting way's indexed line.
- R5: A byte write on a miss, or with sel_n high, changes no stored byte.
- R6: At a rising edge with sel_n and fill_n low, the indexed line of way way_pick takes all of fill_line and the address tag. Byte k of the line is fill_line[8k+7:8k]. The valid bit is left as it was.
- R7: At a rising edge with sel_n and setv_n low, the valid bit of way way_pick at the indexed set takes valid_in. A load and a valid update may happen in the same cycle.
- R8: While fill_n or setv_n is low, only way way_pick is enabled. hit_n and the data path then see only that way. With both strobes high, all four ways are enabled.
- R9: A synchronous reset (rst_n low at a rising edge) clears every valid bit, so no address hits afterwards until a line is made valid again.
- R10: At most one way is active at a time. Two ways holding different tags at the same set each return their own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stores happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears valid bits |
| sel_n | input | 1 | Active-low chip select, gates every access and the hit report |
| rd_n | input | 1 | Active-low read request, gates rdata |
| wr_n | input | 1 | Active-low byte write request |
| fill_n | input | 1 | Active-low line load (data and tag) into the picked way |
| setv_n | input | 1 | Active-low valid-bit update in the picked way |
| addr | input | 12 | Byte address: tag 11:5, set 4:3, offset 2:0 |
| way_pick | input | 2 | Target way for a line load or valid update |
| valid_in | input | 1 | Value written to the valid bit on a valid update |
| wdata | input | 8 | Byte written on a hit |
| fill_line | input | 64 | Line loaded on a fill, byte k in bits 8k+7:8k |
| hit_n | output | 1 | Active-low hit |
| rdata | output | 8 | Byte read from the hitting way, zero otherwise |

## Verification
The bench loads a line without setting its valid bit and expects a miss. A design that set the valid bit as part of the load would hit on stale-tag lines here. It places two different tags at one set in two ways and reads both back. Muddling the way merge or the comparator would return the wrong way's bytes. It holds a valid-bit strobe low while pointing way_pick away from, and then at, the way that holds the address. A design that kept all ways enabled during that strobe would report a hit it must not. It also issues byte writes on a miss and with chip select high, then reads the neighbouring ways and bytes. This catches enables that leak into lines that did not hit.

// File: rtl/wsc_pkg.sv
// Package: shared geometry of the set-associative cache.
// Assumes byte-wide data and power-of-two line, set and way counts.
package wsc_pkg;
    parameter int ADDR_W = 12;             // byte address width
    parameter int OFF_W  = 3;              // byte offset bits
    parameter int IDX_W  = 2;              // set index bits
    parameter int WAY_W  = 2;              // way number bits
    parameter int BYTE_W = 8;              // data width
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_B = 1 << OFF_W;
    localparam int SETS   = 1 << IDX_W;
    localparam int WAYS   = 1 << WAY_W;
    localparam int LINE_W = LINE_B * BYTE_W;

    // Address fields, most significant first
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_t;
endpackage

// File: rtl/way_enable_gen.sv
// Module: way_enable_gen
// Forms the per-way enables. An active-low one-hot decode of way_pick is
// combined with the AND of the two write strobes. Both strobes high keeps
// every way enabled (lookup). Either strobe low leaves only the picked way.
// Assumes strobes are active low.
module way_enable_gen
    import wsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_n,
    input  logic             setv_n,
    input  logic [WAY_W-1:0] way_pick,
    output logic [WAYS-1:0]  way_en
);
    logic             lookup_mode;
    logic [WAYS-1:0]  pick_dec_n;

    // High when neither line load nor valid update is requested
    assign lookup_mode = fill_n & setv_n;

    for (genvar w = 0; w < WAYS; w++) begin : g_dec
        // Active-low decode of the picked way
        assign pick_dec_n[w] = (way_pick != WAY_W'(w));
        // Enable: forced on in lookup, else only the decoded way
        assign way_en[w] = lookup_mode | ~pick_dec_n[w];
    end

    // R8
    single_way_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_n || !setv_n) |-> ($countones(way_en) == 1 && way_en[way_pick]));
endmodule

// File: rtl/cache_way.sv
// Module: cache_way
// One way of the cache: per-set tag, valid bit and line storage, one tag
// comparator and the byte read port. act is high when this way is enabled,
// its indexed line is valid and the tag matches. A line load has priority
// over a byte write in the same cycle. Only valid bits are reset.
module cache_way
    import wsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    input  logic [TAG_W-1:0]  tag,
    input  logic              en,
    input  logic              byte_we,
    input  logic              fill_we,
    input  logic              setv_we,
    input  logic              valid_in,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [LINE_W-1:0] fill_line,
    output logic              act,
    output logic [BYTE_W-1:0] rbyte
);
    logic [LINE_W-1:0] line_q [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [SETS-1:0]   valid_q;
    logic              tag_eq;

    // Valid bits: cleared by reset, updated by the valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (setv_we)
            valid_q[idx] <= valid_in;
    end

    // Line and tag storage: full load or single-byte update
    always_ff @(posedge clk) begin
        if (fill_we) begin
            line_q[idx] <= fill_line;
            tag_q[idx]  <= tag;
        end else if (byte_we) begin
            line_q[idx][int'(off)*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // Tag comparator of this way
    assign tag_eq = (tag_q[idx] == tag);
    // Line activation: indexed, enabled, valid and equal
    assign act    = en & valid_q[idx] & tag_eq;
    // Byte read port at the offset
    assign rbyte  = line_q[idx][int'(off)*BYTE_W +: BYTE_W];

    // R4
    byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |=> ($past(idx) != idx || $past(off) != off || rbyte == $past(wdata)));
    // R6
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && setv_we && valid_in) |=> ($past(idx) != idx || $past(tag) != tag || !en || act));
    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !act);
endmodule

// File: rtl/hit_merge.sv
// Module: hit_merge
// Merges the way activations into one hit and one byte with an AND-OR
// selector. Relies on at most one way being active.
module hit_merge
    import wsc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WAYS-1:0]              act,
    input  logic [WAYS-1:0][BYTE_W-1:0]  way_byte,
    output logic                         any_act,
    output logic [BYTE_W-1:0]            sel_byte
);
    // Any way active
    assign any_act = |act;

    // AND-OR byte selector across the ways
    always_comb begin
        sel_byte = '0;
        for (int w = 0; w < WAYS; w++)
            sel_byte |= way_byte[w] & {BYTE_W{act[w]}};
    end

    // R10
    one_way_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));
endmodule

// File: rtl/setassoc_cache.sv
// Module: setassoc_cache
// Four-way set-associative cache core. Lookup and hit are combinational.
// Loads, valid updates and byte writes happen on the rising clock edge.
// Assumes the requester chooses the victim way and drives it on way_pick.
module setassoc_cache
    import wsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              fill_n,
    input  logic              setv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WAY_W-1:0]  way_pick,
    input  logic              valid_in,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [LINE_W-1:0] fill_line,
    output logic              hit_n,
    output logic [BYTE_W-1:0] rdata
);
    addr_t                        a;
    logic [WAYS-1:0]              way_en;
    logic [WAYS-1:0]              act;
    logic [WAYS-1:0][BYTE_W-1:0]  way_byte;
    logic                         any_act;
    logic [BYTE_W-1:0]            sel_byte;
    logic                         fill_go;
    logic                         setv_go;
    logic                         byte_go;
    logic                         hit;

    // Address field split
    assign a = addr_t'(addr);

    // Qualified strobes: every store needs chip select
    assign fill_go = ~sel_n & ~fill_n;
    assign setv_go = ~sel_n & ~setv_n;
    assign byte_go = ~sel_n & ~wr_n & fill_n & setv_n;

    way_enable_gen u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_n   (fill_n),
        .setv_n   (setv_n),
        .way_pick (way_pick),
        .way_en   (way_en)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache_way u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .idx       (a.idx),
            .off       (a.off),
            .tag       (a.tag),
            .en        (way_en[w]),
            .byte_we   (byte_go & act[w]),
            .fill_we   (fill_go & way_en[w]),
            .setv_we   (setv_go & way_en[w]),
            .valid_in  (valid_in),
            .wdata     (wdata),
            .fill_line (fill_line),
            .act       (act[w]),
            .rbyte     (way_byte[w])
        );
    end

    hit_merge u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .way_byte (way_byte),
        .any_act  (any_act),
        .sel_byte (sel_byte)
    );

    // Hit qualified by chip select
    assign hit   = any_act & ~sel_n;
    assign hit_n = ~hit;
    // Read data only on a selected read hit
    assign rdata = (hit & ~rd_n) ? sel_byte : '0;

    // R2
    no_hit_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> hit_n);
    // R3
    rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || hit_n) |-> (rdata == '0));
endmodule

// File: tb/setassoc_cache_bench.sv
module setassoc_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_n, rd_n, wr_n, fill_n, setv_n;
    logic [11:0] addr;
    logic [1:0]  way_pick;
    logic        valid_in;
    logic [7:0]  wdata;
    logic [63:0] fill_line;
    logic        hit_n;
    logic [7:0]  rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [63:0] LA = 64'h8877_6655_4433_2211;
    localparam logic [63:0] LB = 64'hF0E1_D2C3_B4A5_9687;
    localparam logic [63:0] LD = 64'h0F1E_2D3C_4B5A_6978;

    always #5 clk = ~clk;

    setassoc_cache u_setassoc_cache (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .fill_n(fill_n), .setv_n(setv_n), .addr(addr), .way_pick(way_pick),
        .valid_in(valid_in), .wdata(wdata), .fill_line(fill_line),
        .hit_n(hit_n), .rdata(rdata)
    );

    function automatic logic [11:0] mk(input logic [6:0] t, input logic [1:0] s, input logic [2:0] o);
        return {t, s, o};
    endfunction

    function automatic logic [7:0] byte_of(input logic [63:0] l, input int k);
        return l[k*8 +: 8];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel_n = 1; rd_n = 1; wr_n = 1; fill_n = 1; setv_n = 1;
        way_pick = 0; valid_in = 0; wdata = 0; fill_line = 0; addr = 0;
    endtask

    // Combinational read at a negedge-driven address
    task automatic look(input logic [11:0] ad, input string req, input logic exp_hit_n, input logic [7:0] exp_d);
        @(negedge clk);
        idle(); sel_n = 0; rd_n = 0; addr = ad;
        #1;
        check({req, " hit_n"}, hit_n, exp_hit_n);
        check({req, " rdata"}, rdata, exp_d);
    endtask

    task automatic store(input logic [11:0] ad, input logic [1:0] w, input logic ld, input logic sv,
                         input logic vin, input logic [63:0] l);
        @(negedge clk);
        idle(); sel_n = 0; addr = ad; way_pick = w; fill_n = ~ld; setv_n = ~sv;
        valid_in = vin; fill_line = l;
        @(negedge clk);
        idle();
    endtask

    task automatic bwrite(input logic [11:0] ad, input logic cs_n, input logic [7:0] d);
        @(negedge clk);
        idle(); sel_n = cs_n; wr_n = 0; addr = ad; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        look(mk(7'h00, 2'd0, 3'd0), "R9 reset", 1, 8'h00);
        look(mk(7'h55, 2'd3, 3'd7), "R9 reset", 1, 8'h00);
    endtask

    task automatic t_fill_valid();
        store(mk(7'h2A, 2'd1, 3'd0), 2'd2, 1, 0, 0, LA);
        look(mk(7'h2A, 2'd1, 3'd0), "R6 load keeps valid", 1, 8'h00);
        store(mk(7'h2A, 2'd1, 3'd0), 2'd2, 0, 1, 1, 64'h0);
        look(mk(7'h2A, 2'd1, 3'd0), "R7 R3 off0", 0, byte_of(LA, 0));
        look(mk(7'h2A, 2'd1, 3'd3), "R1 off3", 0, byte_of(LA, 3));
        look(mk(7'h2A, 2'd1, 3'd7), "R1 off7", 0, byte_of(LA, 7));
    endtask

    task automatic t_two_ways();
        store(mk(7'h13, 2'd1, 3'd0), 2'd0, 1, 1, 1, LB);
        look(mk(7'h13, 2'd1, 3'd6), "R10 way0", 0, byte_of(LB, 6));
        look(mk(7'h2A, 2'd1, 3'd6), "R10 way2", 0, byte_of(LA, 6));
        look(mk(7'h2A, 2'd2, 3'd6), "R1 other set", 1, 8'h00);
        look(mk(7'h6A, 2'd1, 3'd6), "R2 tag bit11", 1, 8'h00);
    endtask

    task automatic t_select();
        @(negedge clk);
        idle(); sel_n = 1; rd_n = 0; addr = mk(7'h2A, 2'd1, 3'd1);
        #1;
        check("R2 sel_n high hit_n", hit_n, 1'b1);
        check("R3 sel_n high rdata", rdata, 8'h00);
        sel_n = 0; rd_n = 1;
        #1;
        check("R2 hit without read", hit_n, 1'b0);
        check("R3 rd_n high rdata", rdata, 8'h00);
        bwrite(mk(7'h2A, 2'd1, 3'd2), 1'b1, 8'hEE);
        look(mk(7'h2A, 2'd1, 3'd2), "R5 unselected write", 0, byte_of(LA, 2));
    endtask

    task automatic t_byte_write();
        bwrite(mk(7'h13, 2'd1, 3'd5), 1'b0, 8'h5A);
        look(mk(7'h13, 2'd1, 3'd5), "R4 written byte", 0, 8'h5A);
        look(mk(7'h13, 2'd1, 3'd4), "R4 neighbour byte", 0, byte_of(LB, 4));
        look(mk(7'h2A, 2'd1, 3'd5), "R4 other way", 0, byte_of(LA, 5));
    endtask

    task automatic t_miss_write();
        bwrite(mk(7'h77, 2'd1, 3'd5), 1'b0, 8'hC3);
        look(mk(7'h2A, 2'd1, 3'd5), "R5 miss write way2", 0, byte_of(LA, 5));
        look(mk(7'h13, 2'd1, 3'd5), "R5 miss write way0", 0, 8'h5A);
    endtask

    task automatic t_narrow();
        @(negedge clk);
        idle(); sel_n = 0; rd_n = 0; addr = mk(7'h13, 2'd1, 3'd0);
        setv_n = 0; valid_in = 1; way_pick = 2'd2;
        #1;
        check("R8 strobe other way", hit_n, 1'b1);
        way_pick = 2'd0;
        #1;
        check("R8 strobe holding way", hit_n, 1'b0);
        setv_n = 1; fill_n = 0; way_pick = 2'd1; addr = mk(7'h2A, 2'd1, 3'd0);
        #1;
        check("R8 load other way", hit_n, 1'b1);
        fill_n = 1;
        #1;
        check("R8 all ways back", hit_n, 1'b0);
        @(negedge clk);
        idle();
    endtask

    task automatic t_invalidate();
        store(mk(7'h2A, 2'd1, 3'd0), 2'd2, 0, 1, 0, 64'h0);
        look(mk(7'h2A, 2'd1, 3'd0), "R7 cleared valid", 1, 8'h00);
        look(mk(7'h13, 2'd1, 3'd1), "R7 other way kept", 0, byte_of(LB, 1));
    endtask

    task automatic t_refill();
        look(mk(7'h41, 2'd3, 3'd1), "R6 before load", 1, 8'h00);
        store(mk(7'h41, 2'd3, 3'd1), 2'd3, 1, 1, 1, LD);
        look(mk(7'h41, 2'd3, 3'd1), "R6 retry hits", 0, byte_of(LD, 1));
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        idle(); rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        look(mk(7'h13, 2'd1, 3'd1), "R9 reset mid-run", 1, 8'h00);
        look(mk(7'h41, 2'd3, 3'd1), "R9 reset mid-run", 1, 8'h00);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fill_valid();
        t_two_ways();
        t_select();
        t_byte_write();
        t_miss_write();
        t_narrow();
        t_invalidate();
        t_refill();
        t_reset_again();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule